// File: doc/BRIEF.md
# UART Receive Holding Buffer and Line Status

This block sits behind the register interface of a UART. It accepts finished characters from a receiver front end, and each character comes with break, framing-error and parity-error tags. It holds the characters for the CPU and assembles a six-bit line status word. It also tracks whether the transmit holding storage is empty, and it raises an interrupt request from that condition when software has enabled it. The bus decode and the serial shifting sit outside the block. The block sees only three one-cycle strobes from the bus: a data read, a status read and a transmit write. It also sees one strobe from the transmit shifter, which marks the moment the shifter takes a character.

The block has two modes. In single-register mode a new character overwrites the held one. In FIFO mode up to `DEPTH` characters are queued in arrival order. Every stored entry keeps its own three tags, and the status word shows the tags of the entry at the head only. Overrun follows different rules in each mode. A change of mode flushes the receive storage, the transmit storage and the overrun flag.

Top module: `uart_linestat`

## Requirements
- R1: After reset `line_status` is 6'b100000, `rx_dout` is 0 and `thre_irq` equals `thre_int_en`. The status bits are: bit0 data ready, bit1 overrun, bit2 parity error, bit3 framing error, bit4 break, bit5 transmit holding empty.
- R2: In FIFO mode, characters come out on `rx_dout` in arrival order, with up to `DEPTH` held at once. Data ready is 1 exactly while at least one character is held.
- R3: In FIFO mode, status bits 4:2 equal the {break, framing, parity} tags of the head entry, and they change when a data read advances the head.
- R4: In FIFO mode, a character that arrives while `DEPTH` entries are held and no data read occurs is discarded. The stored contents stay unchanged, and overrun reads 1 from the next cycle. A data read in the same cycle lets that character in, and no overrun results.
- R5: In single-register mode, a character that arrives while an unread one is held replaces it and sets overrun. If a data read occurs in the same cycle, the character is loaded without overrun.
- R6: A status read clears overrun and clears the tags of the current head entry. In FIFO mode the entries behind the head keep their tags. In single-register mode the tags survive a data read and last until a status read or the next character.
- R7: When a status read and a character load fall in the same cycle, the load wins. The new character's tags are shown, and an overrun that the load causes reads 1.
- R8: In single-register mode, transmit holding empty clears on a transmit write and sets on a shift load. A write and a shift load in the same cycle leave it at 0.
- R9: In FIFO mode, transmit holding empty is 1 exactly when the transmit queue of `DEPTH` entries is empty. A write to a full queue is dropped, and a shift load to an empty queue is ignored.
- R10: `thre_irq` is the AND of transmit holding empty and `thre_int_en`.
- R11: A change of `fifo_mode` empties the receive and transmit storage and clears overrun and all tags, which leaves `line_status` at 6'b100000.
- R12: A data read while nothing is held has no effect on `line_status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode | input | 1 | 1 selects FIFO mode, 0 selects single-register mode |
| rx_valid | input | 1 | A completed character is offered this cycle |
| rx_data | input | 8 | Received character |
| rx_break | input | 1 | Break tag of the offered character |
| rx_frame_err | input | 1 | Framing-error tag of the offered character |
| rx_parity_err | input | 1 | Parity-error tag of the offered character |
| rd_data_stb | input | 1 | CPU reads the receive data register |
| rd_status_stb | input | 1 | CPU reads the line status word |
| tx_write_stb | input | 1 | CPU writes a transmit character |
| tx_shift_load | input | 1 | Transmit shifter takes a character |
| thre_int_en | input | 1 | Transmit-holding-empty interrupt enable |
| rx_dout | output | 8 | Character at the receive head |
| line_status | output | 6 | Line status word |
| thre_irq | output | 1 | Transmit-holding-empty interrupt request |

## Verification
On every cycle the assertions check these rules:
- the receive level stays within its bound in each mode;
- a discarded character leaves the level unchanged;
- overrun follows its set-over-clear rule;
- a transmit write always clears transmit holding empty;
- the interrupt never rises without its enable.

Only the bench scenarios can show that data and tags arrive in order with the right character. They also show the clearing of head tags alone, the survival of tags after a single-mode data read, and the drop of a seventeenth transmit write.

// File: rtl/uls_pkg.sv
package uls_pkg;
  parameter int ULS_DATA_W = 8;

  typedef struct packed {
    logic                  brk;
    logic                  fe;
    logic                  pe;
    logic [ULS_DATA_W-1:0] data;
  } uls_entry_t;

  // Level after one cycle: pop only when non-empty, then push, then clamp to cap.
  function automatic int unsigned uls_next_level(int unsigned level, logic push,
                                                 logic pop, int unsigned cap);
    int unsigned n;
    n = level;
    if (pop && n != 0) n = n - 1;
    if (push) n = n + 1;
    if (n > cap) n = cap;
    return n;
  endfunction

  function automatic int unsigned uls_ptr_next(int unsigned ptr, int unsigned depth);
    return (ptr + 1 >= depth) ? 0 : ptr + 1;
  endfunction

  // Status word: {thre, brk, fe, pe, ovr, dr}
  function automatic logic [5:0] uls_status(logic thre, uls_entry_t head,
                                            logic ovr, logic dr);
    return {thre, head.brk, head.fe, head.pe, ovr, dr};
  endfunction
endpackage

// File: rtl/uls_rx_store.sv
module uls_rx_store
  import uls_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             fifo_mode,
  input  logic             push,
  input  uls_entry_t       push_entry,
  input  logic             pop_req,
  input  logic             clr_tags,
  output uls_entry_t       head,
  output logic [CNT_W-1:0] count,
  output logic             drop,
  output logic             replace
);
  uls_entry_t       mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr, wr_slot;
  logic             pop, full, accept, empty, clr_ok;
  int unsigned      cap;

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign pop     = pop_req && !empty;
  assign cap     = fifo_mode ? DEPTH : 1;
  assign accept  = fifo_mode ? (push && (!full || pop)) : push;
  assign drop    = fifo_mode && push && full && !pop;
  assign replace = !fifo_mode && push && !empty && !pop;
  assign wr_slot = fifo_mode ? wr_ptr : rd_ptr;
  // In FIFO mode only a present, staying head is cleared; in single mode the tags persist.
  assign clr_ok  = clr_tags && (fifo_mode ? (!empty && !pop) : 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (clr_ok) begin
        mem[rd_ptr].brk <= 1'b0;
        mem[rd_ptr].fe  <= 1'b0;
        mem[rd_ptr].pe  <= 1'b0;
      end
      if (accept) mem[wr_slot] <= push_entry;   // later assignment: load wins
      if (fifo_mode) begin
        if (accept) wr_ptr <= PTR_W'(uls_ptr_next(int'(wr_ptr), DEPTH));
        if (pop)    rd_ptr <= PTR_W'(uls_ptr_next(int'(rd_ptr), DEPTH));
      end
      count <= CNT_W'(uls_next_level(int'(count), accept, pop, cap));
    end
  end

  always_comb begin
    if (fifo_mode) head = empty ? '0 : mem[rd_ptr];
    else           head = mem[rd_ptr];
  end

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  p_single_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode && !flush |-> count <= CNT_W'(1));
  p_drop_keeps_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drop && !flush |=> count == $past(count));
  p_drop_when_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> count == CNT_W'(DEPTH));
endmodule

// File: rtl/uls_line_flags.sv
module uls_line_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic set_ovr,
  input  logic rd_status,
  output logic ovr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ovr <= 1'b0;
    else if (flush)     ovr <= 1'b0;
    else if (set_ovr)   ovr <= 1'b1;   // a load that overruns beats the read
    else if (rd_status) ovr <= 1'b0;
  end

  p_ovr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_ovr && !flush |=> ovr);
  p_ovr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status && !set_ovr && !flush |=> !ovr);
endmodule

// File: rtl/uls_tx_track.sv
module uls_tx_track
  import uls_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic fifo_mode,
  input  logic tx_wr,
  input  logic tx_shift,
  output logic thre
);
  logic [CNT_W-1:0] level;
  logic             pop, push_ok;
  int unsigned      cap;

  assign cap     = fifo_mode ? DEPTH : 1;
  assign pop     = tx_shift && (level != '0);
  // single mode: a write always lands in the holding register (overwrite)
  assign push_ok = fifo_mode ? (tx_wr && ((level != CNT_W'(DEPTH)) || pop)) : tx_wr;
  assign thre    = (level == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     level <= '0;
    else if (flush) level <= '0;
    else            level <= CNT_W'(uls_next_level(int'(level), push_ok, pop, cap));
  end

  p_write_clears_thre_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr && !flush |=> !thre);
  p_shift_sets_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode && tx_shift && !tx_wr && !flush |=> thre);
endmodule

// File: rtl/uart_linestat.sv
module uart_linestat
  import uls_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int DW = ULS_DATA_W,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_mode,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_break,
  input  logic          rx_frame_err,
  input  logic          rx_parity_err,
  input  logic          rd_data_stb,
  input  logic          rd_status_stb,
  input  logic          tx_write_stb,
  input  logic          tx_shift_load,
  input  logic          thre_int_en,
  output logic [DW-1:0] rx_dout,
  output logic [5:0]    line_status,
  output logic          thre_irq
);
  logic             mode_q, flush;
  uls_entry_t       in_entry, head;
  logic [CNT_W-1:0] rx_count;
  logic             rx_drop, rx_replace, set_ovr, ovr, thre, data_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= fifo_mode;
  end
  assign flush = (mode_q != fifo_mode);

  assign in_entry = '{brk: rx_break, fe: rx_frame_err, pe: rx_parity_err, data: rx_data};

  uls_rx_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .fifo_mode  (fifo_mode),
    .push       (rx_valid),
    .push_entry (in_entry),
    .pop_req    (rd_data_stb),
    .clr_tags   (rd_status_stb),
    .head       (head),
    .count      (rx_count),
    .drop       (rx_drop),
    .replace    (rx_replace)
  );

  assign set_ovr = rx_drop || rx_replace;

  uls_line_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .set_ovr   (set_ovr),
    .rd_status (rd_status_stb),
    .ovr       (ovr)
  );

  uls_tx_track #(.DEPTH(DEPTH)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .fifo_mode (fifo_mode),
    .tx_wr     (tx_write_stb),
    .tx_shift  (tx_shift_load),
    .thre      (thre)
  );

  assign data_ready  = (rx_count != '0);
  assign rx_dout     = head.data;
  assign line_status = uls_status(thre, head, ovr, data_ready);
  assign thre_irq    = thre && thre_int_en;

  p_irq_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    thre_irq |-> thre_int_en);
  p_ready_after_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_drop && !flush |=> line_status[0]);
  p_flush_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> line_status[4:0] == 5'b0);
endmodule

// File: tb/uart_linestat_bench.sv
module uart_linestat_bench;
  logic       clk = 0, rst_n = 0;
  logic       fifo_mode = 0, rx_valid = 0, rx_break = 0, rx_frame_err = 0, rx_parity_err = 0;
  logic [7:0] rx_data = 0;
  logic       rd_data_stb = 0, rd_status_stb = 0, tx_write_stb = 0, tx_shift_load = 0;
  logic       thre_int_en = 0;
  logic [7:0] rx_dout;
  logic [5:0] line_status;
  logic       thre_irq;
  int         n_tests = 0, n_fail = 0;
  bit         done = 0;
  logic [10:0] mq[$];   // model queue: {brk, fe, pe, data}

  always #2 clk = ~clk;

  uart_linestat u_uart_linestat (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one cycle of strobes, return just after the following negedge
  task automatic go(input logic rv, input logic [7:0] d, input logic [2:0] t,
                    input logic rdd, input logic rds, input logic txw, input logic txs);
    rx_valid = rv; rx_data = d; {rx_break, rx_frame_err, rx_parity_err} = t;
    rd_data_stb = rdd; rd_status_stb = rds; tx_write_stb = txw; tx_shift_load = txs;
    @(negedge clk);
    rx_valid = 0; rd_data_stb = 0; rd_status_stb = 0; tx_write_stb = 0; tx_shift_load = 0;
  endtask

  function automatic logic [7:0] dat(int i, int r); return 8'((i * 37 + r * 101 + 11) % 256); endfunction
  function automatic logic [2:0] tg(int i, int r);  return 3'((i + 3 * r) % 8); endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", line_status, 6'b100000);
    chk("R1 dout", rx_dout, 8'h00);
    chk("R1 irq off", thre_irq, 0);
    thre_int_en = 1; #1;
    chk("R1 irq on", thre_irq, 1);
    thre_int_en = 0;

    // FIFO mode sweeps
    fifo_mode = 1; @(negedge clk);
    chk("R11 enter fifo", line_status, 6'b100000);
    for (int r = 0; r < 2; r++) begin
      mq.delete();
      for (int i = 0; i < 16; i++) begin
        go(1, dat(i, r), tg(i, r), 0, 0, 0, 0);
        mq.push_back({tg(i, r), dat(i, r)});
        chk("R2 ready", line_status[0], 1);
      end
      chk("R3 head tags", line_status[4:2], tg(0, r));
      chk("R4 no ovr yet", line_status[1], 0);
      if (r == 0) begin
        go(1, 8'hEE, 3'b111, 0, 0, 0, 0);   // dropped
        chk("R4 overrun", line_status[1], 1);
        chk("R4 head kept", rx_dout, dat(0, r));
        go(0, 0, 0, 0, 1, 0, 0);
        chk("R6 ovr cleared", line_status[1], 0);
        chk("R6 head tags cleared", line_status[4:2], 3'b000);
        mq[0][10:8] = 3'b000;
      end else begin
        go(1, 8'h5A, 3'b110, 1, 0, 0, 0);   // read and load while full
        void'(mq.pop_front());
        mq.push_back({3'b110, 8'h5A});
        chk("R4 read lets in", line_status[1], 0);
      end
      for (int i = 0; i < 16; i++) begin
        chk("R2 order", rx_dout, mq[0][7:0]);
        chk("R3 tags", line_status[4:2], mq[0][10:8]);
        chk("R2 ready held", line_status[0], 1);
        go(0, 0, 0, 1, 0, 0, 0);
        void'(mq.pop_front());
      end
      chk("R2 empty", line_status[0], 0);
    end
    go(0, 0, 0, 1, 0, 0, 0);
    chk("R12 empty read", line_status, 6'b100000);
    // R7 in FIFO mode: load into empty buffer with a status read
    go(1, 8'h33, 3'b011, 0, 1, 0, 0);
    chk("R7 fifo load wins", line_status, 6'b101101);
    // fill and overrun, then flush by mode change
    for (int i = 0; i < 16; i++) go(1, 8'(i), 0, 0, 0, 0, 0);
    chk("R4 ovr before flush", line_status[1], 1);
    fifo_mode = 0; @(negedge clk);
    chk("R11 flush", line_status, 6'b100000);

    // single-register mode
    go(1, 8'hA1, 3'b001, 0, 0, 0, 0);
    chk("R5 load", line_status, 6'b100101);
    chk("R5 data", rx_dout, 8'hA1);
    go(1, 8'hB2, 3'b000, 0, 0, 0, 0);
    chk("R5 replace ovr", line_status, 6'b100011);
    chk("R5 replaced data", rx_dout, 8'hB2);
    go(1, 8'hC3, 3'b101, 0, 1, 0, 0);
    chk("R7 load beats status read", line_status, 6'b110111);
    go(0, 0, 0, 0, 1, 0, 0);
    chk("R6 status read clears", line_status, 6'b100001);
    go(0, 0, 0, 1, 0, 0, 0);
    chk("R5 read empties", line_status, 6'b100000);
    go(1, 8'hD4, 3'b010, 0, 0, 0, 0);
    go(0, 0, 0, 1, 0, 0, 0);
    chk("R6 tags persist after data read", line_status, 6'b101000);
    go(0, 0, 0, 0, 1, 0, 0);
    chk("R6 tags cleared", line_status, 6'b100000);
    go(1, 8'hE5, 0, 0, 0, 0, 0);
    go(1, 8'hF6, 0, 1, 0, 0, 0);
    chk("R5 read same cycle no ovr", line_status, 6'b100001);
    chk("R5 data after", rx_dout, 8'hF6);

    // transmit, single mode
    thre_int_en = 1;
    go(0, 0, 0, 0, 0, 1, 0);
    chk("R8 write clears", line_status[5], 0);
    chk("R10 irq low", thre_irq, 0);
    go(0, 0, 0, 0, 0, 1, 1);
    chk("R8 write+shift", line_status[5], 0);
    go(0, 0, 0, 0, 0, 0, 1);
    chk("R8 shift sets", line_status[5], 1);
    chk("R10 irq high", thre_irq, 1);
    thre_int_en = 0; #1;
    chk("R10 irq masked", thre_irq, 0);
    go(0, 0, 0, 0, 0, 0, 1);
    chk("R8 idle shift", line_status[5], 1);

    // transmit, FIFO mode
    fifo_mode = 1; @(negedge clk);
    for (int i = 0; i < 17; i++) go(0, 0, 0, 0, 0, 1, 0);
    for (int k = 1; k <= 17; k++) begin
      go(0, 0, 0, 0, 0, 0, 1);
      chk("R9 level", line_status[5], (k >= 16) ? 1 : 0);
    end
    for (int ie = 0; ie < 2; ie++) begin
      thre_int_en = 1'(ie); #1;
      chk("R10 irq sweep", thre_irq, ie);
    end
    go(0, 0, 0, 0, 0, 1, 0);
    fifo_mode = 0; @(negedge clk);
    chk("R11 tx flush", line_status[5], 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule